// File: doc/BRIEF.md
# Integer Arithmetic Decode-and-Execute Unit

This unit takes one 32-bit fixed-length instruction word together with the two source operand values already read from the register file. In the same cycle it recognises the register-register and 12-bit-immediate integer operations: add, subtract, set-less-than, bitwise logic, shifts and multiply. It returns the result, a destination write enable and the three register index fields. It has no clock and no state, so it sits between the operand read stage and the write-back stage of a pipeline.

Words belonging to other instruction groups are not executed. These groups are division, memory access, control transfer, privileged and system operations. For such a word the unit raises `foreign` so that another unit can take it. A word that fits no known group raises `illegal`.

Because the unit is purely combinational, it has no valid/ready handshake. The pipeline stage around it owns any flow control, and a stall upstream just holds the inputs steady.

Top module: `ialu_top`

## Requirements
- R1: `rd_idx`, `rj_idx` and `rk_idx` always equal instruction bits [4:0], [9:5] and [14:10] respectively, whatever the word is.
- R2: When bits [31:15] equal 0x20, 0x22, 0x28, 0x29, 0x2A or 0x2B, the result is A+B, A-B, ~(A|B), A&B, A|B or A^B respectively, all modulo 2^32.
- R3: Bits [31:15] = 0x24 give a signed comparison and 0x25 an unsigned one. The result is 1 when A < B and 0 otherwise.
- R4: Bits [31:15] = 0x2E, 0x2F and 0x30 shift A left logically, right logically and right arithmetically. The shift amount is B[4:0], and B[31:5] has no effect.
- R5: Bits [31:15] = 0x38, 0x39 and 0x3A return, in that order, the low word of A*B, the high word of the signed 64-bit product and the high word of the unsigned 64-bit product.
- R6: When bits [31:22] = 0x00A, 0x008 or 0x009, bits [21:10] are sign-extended to 32 bits and the operation is add, signed less-than or unsigned less-than against A, in that order.
- R7: When bits [31:22] = 0x00D, 0x00E or 0x00F, bits [21:10] are zero-extended and the operation is AND, OR or XOR against A, in that order.
- R8: When bits [31:15] = 0x81, 0x89 or 0x91, A is shifted left, right logically or right arithmetically by bits [14:10]. Operand B has no effect.
- R9: `rd_we` is 1 exactly when the word is one of the encodings in R2–R8 and bits [4:0] are not zero. A destination of register 0 therefore never produces a write.
- R10: `foreign` is 1, `illegal` is 0, `rd_we` is 0 and `result` is 0 for any word in these groups. Bits [31:26] equal to 0x01, 0x0A, or any value from 0x13 to 0x1B. Bits [31:25] equal to 0x0A, 0x0E or 0x10. Bits [31:15] equal to 0x40–0x43, 0x54, 0x56, 0x070E4 or 0x070E5. Bits [31:15] equal to 0 with bits [14:10] equal to 0x18 or 0x19.
- R11: A word matching neither R2–R8 nor R10 gives `illegal` = 1, `foreign` = 0, `rd_we` = 0 and `result` = 0. Examples are the all-zero word, bits [31:15] = 0x21, and bits [31:22] = 0x00B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| rd_idx | output | 5 | Destination register field |
| rj_idx | output | 5 | First source register field |
| rk_idx | output | 5 | Second source register / shift amount field |
| result | output | 32 | Computed value; 0 when the word is not executed here |
| rd_we | output | 1 | Destination write enable |
| foreign | output | 1 | Word belongs to a group handled elsewhere |
| illegal | output | 1 | Word matches no known group |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, 5-bit register fields, a 12-bit immediate and a 5-bit shift amount. These values match the instruction layout exactly, so every opcode, immediate sign edge (0x7FF/0x800/0xFFF) and shift extreme (0 and 31) can be reached. The vector table covers each executed opcode with operands chosen at the signed/unsigned boundaries, so that signed and unsigned paths give different answers. Directed words then probe each out-of-scope group, the holes between opcodes, and destination register 0.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int XW      = 32;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 12;
  localparam int SH_W    = 5;
  localparam int OP17_W  = 17;
  localparam int OP10_W  = 10;
  localparam int PROD_W  = 2 * XW;

  typedef enum logic [3:0] {
    AOP_ADD, AOP_SUB, AOP_SLT, AOP_SLTU,
    AOP_NOR, AOP_AND, AOP_OR,  AOP_XOR,
    AOP_SLL, AOP_SRL, AOP_SRA,
    AOP_MUL, AOP_MULH, AOP_MULHU
  } alu_op_e;

  typedef enum logic [1:0] {
    KIND_BAD   = 2'd0,
    KIND_OWN   = 2'd1,
    KIND_OTHER = 2'd2
  } word_kind_e;
endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [XW-1:0] instr,
  input  logic [XW-1:0] src_b,
  output alu_op_e       op,
  output logic [XW-1:0] opnd_b,
  output word_kind_e    kind
);
  localparam int EXT_W = XW - IMM_W;
  localparam int PAD_W = XW - SH_W;

  logic [OP17_W-1:0] op17;
  logic [OP10_W-1:0] op10;
  logic [5:0]        top6;
  logic [6:0]        top7;
  logic [IMM_W-1:0]  imm;
  logic              own_rr, own_shi, own_imm, other;

  assign op17 = instr[31:15];
  assign op10 = instr[31:22];
  assign top6 = instr[31:26];
  assign top7 = instr[31:25];
  assign imm  = instr[21:10];

  always_comb begin
    op      = AOP_ADD;
    opnd_b  = src_b;
    own_rr  = 1'b1;
    own_shi = 1'b1;
    own_imm = 1'b1;
    case (op17)
      17'h20:  op = AOP_ADD;
      17'h22:  op = AOP_SUB;
      17'h24:  op = AOP_SLT;
      17'h25:  op = AOP_SLTU;
      17'h28:  op = AOP_NOR;
      17'h29:  op = AOP_AND;
      17'h2A:  op = AOP_OR;
      17'h2B:  op = AOP_XOR;
      17'h2E:  op = AOP_SLL;
      17'h2F:  op = AOP_SRL;
      17'h30:  op = AOP_SRA;
      17'h38:  op = AOP_MUL;
      17'h39:  op = AOP_MULH;
      17'h3A:  op = AOP_MULHU;
      default: own_rr = 1'b0;
    endcase
    if (!own_rr) begin
      opnd_b = {{PAD_W{1'b0}}, instr[14:10]};
      case (op17)
        17'h81:  op = AOP_SLL;
        17'h89:  op = AOP_SRL;
        17'h91:  op = AOP_SRA;
        default: own_shi = 1'b0;
      endcase
    end else begin
      own_shi = 1'b0;
    end
    if (!own_rr && !own_shi) begin
      opnd_b = {{EXT_W{imm[IMM_W-1]}}, imm};
      case (op10)
        10'h008: op = AOP_SLT;
        10'h009: op = AOP_SLTU;
        10'h00A: op = AOP_ADD;
        10'h00D: begin op = AOP_AND; opnd_b = {{EXT_W{1'b0}}, imm}; end
        10'h00E: begin op = AOP_OR;  opnd_b = {{EXT_W{1'b0}}, imm}; end
        10'h00F: begin op = AOP_XOR; opnd_b = {{EXT_W{1'b0}}, imm}; end
        default: own_imm = 1'b0;
      endcase
    end else begin
      own_imm = 1'b0;
    end
  end

  // Groups executed by other units
  always_comb begin
    other = 1'b0;
    if (top6 == 6'h01 || top6 == 6'h0A || (top6 >= 6'h13 && top6 <= 6'h1B))
      other = 1'b1;
    if (top7 == 7'h0A || top7 == 7'h0E || top7 == 7'h10)
      other = 1'b1;
    if ((op17 >= 17'h40 && op17 <= 17'h43) || op17 == 17'h54 || op17 == 17'h56 ||
        op17 == 17'h070E4 || op17 == 17'h070E5)
      other = 1'b1;
    if (op17 == 17'h0 && (instr[14:10] == 5'h18 || instr[14:10] == 5'h19))
      other = 1'b1;
  end

  always_comb begin
    if (own_rr || own_shi || own_imm) kind = KIND_OWN;
    else if (other)                   kind = KIND_OTHER;
    else                              kind = KIND_BAD;
  end

  // The executed encodings and the foreign groups never overlap
  always_comb begin
    p_groups_disjoint_r10: assert (!(other && (own_rr || own_shi || own_imm)))
      else $error("executed encoding also matches a foreign group");
    p_single_form_r8: assert ($countones({own_rr, own_shi, own_imm}) <= 1)
      else $error("more than one instruction form matched");
  end
endmodule

// File: rtl/ialu_mul.sv
module ialu_mul
  import ialu_pkg::*;
(
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic          signed_ops,
  output logic [XW-1:0] prod_lo,
  output logic [XW-1:0] prod_hi
);
  logic signed [XW:0]       a_ext, b_ext;
  logic signed [PROD_W+1:0] prod;

  assign a_ext   = {signed_ops & a[XW-1], a};
  assign b_ext   = {signed_ops & b[XW-1], b};
  assign prod    = a_ext * b_ext;
  assign prod_lo = prod[XW-1:0];
  assign prod_hi = prod[PROD_W-1:XW];

  logic unused_top;
  assign unused_top = ^prod[PROD_W+1:PROD_W];
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] res
);
  logic [SH_W-1:0] sh;
  logic [XW-1:0]   lo, hi;
  logic            lt_s, lt_u;

  assign sh   = b[SH_W-1:0];
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  ialu_mul u_mul (
    .a          (a),
    .b          (b),
    .signed_ops (op != AOP_MULHU),
    .prod_lo    (lo),
    .prod_hi    (hi)
  );

  always_comb begin
    case (op)
      AOP_ADD:   res = a + b;
      AOP_SUB:   res = a - b;
      AOP_SLT:   res = {{(XW-1){1'b0}}, lt_s};
      AOP_SLTU:  res = {{(XW-1){1'b0}}, lt_u};
      AOP_NOR:   res = ~(a | b);
      AOP_AND:   res = a & b;
      AOP_OR:    res = a | b;
      AOP_XOR:   res = a ^ b;
      AOP_SLL:   res = a << sh;
      AOP_SRL:   res = a >> sh;
      AOP_SRA:   res = $unsigned($signed(a) >>> sh);
      AOP_MUL:   res = lo;
      AOP_MULH,
      AOP_MULHU: res = hi;
      default:   res = '0;
    endcase
  end

  always_comb begin
    p_cmp_bool_r3: assert (!(op inside {AOP_SLT, AOP_SLTU}) || res[XW-1:1] == '0)
      else $error("compare result wider than one bit");
    p_mul_low_same_r5: assert (op != AOP_MUL || lo == a * b)
      else $error("low product word depends on signedness");
  end
endmodule

// File: rtl/ialu_top.sv
module ialu_top
  import ialu_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [4:0]  rd_idx,
  output logic [4:0]  rj_idx,
  output logic [4:0]  rk_idx,
  output logic [31:0] result,
  output logic        rd_we,
  output logic        foreign,
  output logic        illegal
);
  alu_op_e       op;
  logic [XW-1:0] opnd_b, ex_res;
  word_kind_e    kind;

  assign rd_idx = instr[RIDX_W-1:0];
  assign rj_idx = instr[2*RIDX_W-1:RIDX_W];
  assign rk_idx = instr[3*RIDX_W-1:2*RIDX_W];

  ialu_decode u_dec (
    .instr  (instr),
    .src_b  (src_b),
    .op     (op),
    .opnd_b (opnd_b),
    .kind   (kind)
  );

  ialu_exec u_exe (
    .op  (op),
    .a   (src_a),
    .b   (opnd_b),
    .res (ex_res)
  );

  assign result  = (kind == KIND_OWN) ? ex_res : '0;
  assign rd_we   = (kind == KIND_OWN) && (rd_idx != '0);
  assign foreign = (kind == KIND_OTHER);
  assign illegal = (kind == KIND_BAD);

  always_comb begin
    p_no_zero_write_r9: assert (rd_idx != '0 || !rd_we)
      else $error("write to register 0");
    p_flags_apart_r11: assert (!(foreign && illegal) && !(rd_we && (foreign || illegal)))
      else $error("status flags overlap");
    p_quiet_foreign_r10: assert (!foreign || result == '0)
      else $error("foreign word produced a result");
    p_quiet_illegal_r11: assert (!illegal || result == '0)
      else $error("illegal word produced a result");
  end
endmodule

// File: tb/ialu_top_tb.sv
module ialu_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] instr, src_a, src_b, result;
  logic [4:0]  rd_idx, rj_idx, rk_idx;
  logic        rd_we, foreign, illegal;
  int total = 0;
  int bad   = 0;

  ialu_top u_dut (
    .instr(instr), .src_a(src_a), .src_b(src_b),
    .rd_idx(rd_idx), .rj_idx(rj_idx), .rk_idx(rk_idx),
    .result(result), .rd_we(rd_we), .foreign(foreign), .illegal(illegal)
  );

  localparam int NV = 24;
  // {instr, src_a, src_b, expected}
  localparam logic [127:0] VT [NV] = '{
    {17'h20, 5'd3, 5'd2, 5'd1, 32'd5,        32'd7,        32'd12},        // R2 add
    {17'h22, 5'd3, 5'd2, 5'd1, 32'd5,        32'd7,        32'hFFFFFFFE},  // R2 sub
    {17'h28, 5'd3, 5'd2, 5'd1, 32'h0F0F0000, 32'h00F000F0, 32'hF000FF0F},  // R2 nor
    {17'h29, 5'd3, 5'd2, 5'd1, 32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00},  // R2 and
    {17'h2A, 5'd3, 5'd2, 5'd1, 32'hFF00FF00, 32'h0FF00FF0, 32'hFFF0FFF0},  // R2 or
    {17'h2B, 5'd3, 5'd2, 5'd1, 32'hFF00FF00, 32'h0FF00FF0, 32'hF0F0F0F0},  // R2 xor
    {17'h24, 5'd3, 5'd2, 5'd1, 32'hFFFFFFFF, 32'd1,        32'd1},         // R3 signed
    {17'h25, 5'd3, 5'd2, 5'd1, 32'hFFFFFFFF, 32'd1,        32'd0},         // R3 unsigned
    {17'h2E, 5'd3, 5'd2, 5'd1, 32'd1,        32'h00000024, 32'h00000010},  // R4 sll
    {17'h2F, 5'd3, 5'd2, 5'd1, 32'h80000000, 32'hFFFFFFFF, 32'd1},         // R4 srl
    {17'h30, 5'd3, 5'd2, 5'd1, 32'h80000000, 32'h00000021, 32'hC0000000},  // R4 sra
    {17'h38, 5'd3, 5'd2, 5'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1},         // R5 mul
    {17'h39, 5'd3, 5'd2, 5'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0},         // R5 mulh
    {17'h3A, 5'd3, 5'd2, 5'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE},  // R5 mulhu
    {17'h39, 5'd3, 5'd2, 5'd1, 32'h80000000, 32'd2,        32'hFFFFFFFF},  // R5 mulh neg
    {10'h00A, 12'hFFF, 5'd5, 5'd4, 32'd16,   32'd0,        32'd15},        // R6 addi
    {10'h008, 12'h800, 5'd5, 5'd4, 32'hFFFFF7FF, 32'd0,    32'd1},         // R6 slti
    {10'h009, 12'hFFF, 5'd5, 5'd4, 32'h7FFFFFFF, 32'd0,    32'd1},         // R6 sltui
    {10'h00D, 12'hFFF, 5'd5, 5'd4, 32'hFFFFFFFF, 32'd0,    32'h00000FFF},  // R7 andi
    {10'h00E, 12'h800, 5'd5, 5'd4, 32'd0,        32'd0,    32'h00000800},  // R7 ori
    {10'h00F, 12'hFFF, 5'd5, 5'd4, 32'hFFFFF000, 32'd0,    32'hFFFFFFFF},  // R7 xori
    {17'h81, 5'd31, 5'd5, 5'd4, 32'd3,        32'h12345678, 32'h80000000}, // R8 slli
    {17'h89, 5'd4,  5'd5, 5'd4, 32'hF0000000, 32'hFFFFFFFF, 32'h0F000000}, // R8 srli
    {17'h91, 5'd8,  5'd5, 5'd4, 32'h80000000, 32'h00000001, 32'hFF800000}  // R8 srai
  };
  localparam int VR [NV] = '{2,2,2,2,2,2,3,3,4,4,4,5,5,5,5,6,6,6,7,7,7,8,8,8};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    instr <= w; src_a <= a; src_b <= b;
    @(negedge clk);
  endtask

  task automatic chk_quiet(input string tag, input logic [31:0] w, input logic exp_foreign);
    apply(w, 32'hDEADBEEF, 32'h01234567);
    chk({tag, " foreign"}, {31'd0, foreign}, {31'd0, exp_foreign});
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, !exp_foreign});
    chk({tag, " we"}, {31'd0, rd_we}, 32'd0);
    chk({tag, " result"}, result, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr = '0; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: all-zero word held during reset
    chk("R11 reset illegal", {31'd0, illegal}, 32'd1);
    chk("R11 reset we", {31'd0, rd_we}, 32'd0);
    chk("R11 reset result", result, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i][127:96], VT[i][95:64], VT[i][63:32]);
      chk($sformatf("R%0d vec%0d result", VR[i], i), result, VT[i][31:0]);
      chk($sformatf("R9 vec%0d we", i), {31'd0, rd_we}, 32'd1);
      chk($sformatf("R11 vec%0d flags", i), {30'd0, foreign, illegal}, 32'd0);
    end

    // R1 field extraction
    apply(32'h12345678, 32'd0, 32'd0);
    chk("R1 rd", {27'd0, rd_idx}, 32'h18);
    chk("R1 rj", {27'd0, rj_idx}, 32'd19);
    chk("R1 rk", {27'd0, rk_idx}, 32'd21);

    // R9 destination zero never writes
    apply({17'h20, 5'd3, 5'd2, 5'd0}, 32'd5, 32'd7);
    chk("R9 rd0 we", {31'd0, rd_we}, 32'd0);
    chk("R9 rd0 flags", {30'd0, foreign, illegal}, 32'd0);

    // R4 shift by zero and upper B ignored
    apply({17'h2E, 5'd3, 5'd2, 5'd1}, 32'hA5A5A5A5, 32'hFFFFFFE0);
    chk("R4 shift zero", result, 32'hA5A5A5A5);

    // R8 register B ignored for immediate shifts
    apply({17'h91, 5'd0, 5'd5, 5'd4}, 32'h80000001, 32'hFFFFFFFF);
    chk("R8 srai zero", result, 32'h80000001);

    // R6 positive immediate edge
    apply({10'h00A, 12'h7FF, 5'd5, 5'd4}, 32'd1, 32'hFFFFFFFF);
    chk("R6 addi 7ff", result, 32'h00000800);

    // R10 foreign groups
    chk_quiet("R10 div",    {17'h40, 15'h0443}, 1'b1);
    chk_quiet("R10 branch", {6'h16, 26'h0000421}, 1'b1);
    chk_quiet("R10 load",   {10'h0A2, 22'h000421}, 1'b1);
    chk_quiet("R10 csr",    {8'h04, 24'h000021}, 1'b1);
    chk_quiet("R10 cntrd",  {17'h0, 5'h18, 5'd0, 5'd4}, 1'b1);
    chk_quiet("R10 lu12i",  {7'h0A, 25'h0000025}, 1'b1);
    chk_quiet("R10 barrier",{17'h070E4, 15'h0}, 1'b1);

    // R11 holes in the encoding space
    chk_quiet("R11 rr hole",  {17'h21, 5'd3, 5'd2, 5'd1}, 1'b0);
    chk_quiet("R11 imm hole", {10'h00B, 12'h123, 5'd5, 5'd4}, 1'b0);
    chk_quiet("R11 shi hole", {17'h82, 5'd3, 5'd2, 5'd1}, 1'b0);
    chk_quiet("R11 top hole", {6'h3F, 26'h0}, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule